// File: doc/BRIEF.md
# Scrolling Reel Sprite Fetch Controller

This block sits between a video timing generator and a set of block-RAM sprite memories. For each screen pixel it decides whether the pixel falls inside one of three side-by-side reel windows. If it does, the block works out which symbol, which 256-word bank, which word and which 4-bit nibble hold the colour for that pixel. Each symbol is a 64x64 sprite drawn at 128x128, so every stored pixel covers a 2x2 square on screen. Symbols are stored back to back, which makes a reel strip one tall column of symbols. Each reel has a scroll offset, counted in sprite rows, that moves the window down that column.

The sprite memory has a registered output and returns data two cycles after the address is presented. The block therefore delays the valid flag, the in-window flag and the nibble select by the same two cycles, so that the returned word and its pixel metadata arrive together. The colour is the low three bits of the selected nibble, one bit each for red, green and blue.

Each reel steps its offset once per frame, on a start-of-frame pulse, while its spin input is high. When spin drops, the reel keeps stepping until its offset lands on the first row of its chosen stop symbol. It then holds there and raises a done flag.

Top module: `reel_sprite_fetch`

## Requirements
- R1: Inside a reel window the sprite column is (x - window left) >> 1 and the sprite row is (y - window top) >> 1, so each sprite pixel covers a 2x2 block of screen pixels.
- R2: For sprite row `row` and column `col` within a symbol, the word index is row*16 + (col >> 2). rom_bank is word index bits [9:8], rom_addr is bits [7:0], and rom_sym is the symbol number. The nibble at bits [4k+3:4k] of the returned word is selected by k = col[1:0], with nibble 0 at bits [3:0]. pix_rgb is bits [2:0] of that nibble, and nibble bit 3 is ignored.
- R3: pix_valid and pix_rgb for a pixel whose inputs are applied before clock edge n become visible after edge n+1, which matches a two-cycle registered memory read. A new pixel can be accepted every cycle.
- R4: When pix_active is low, or the pixel lies outside every reel window, rom_en is 0 and pix_rgb is 0 two cycles later. pix_valid always equals pix_active delayed by two cycles.
- R5: The scrolled row is (offset + sprite row) mod (N_SYMBOLS*64). A row past the end of a symbol reads from the next symbol, and a row past the last symbol wraps to symbol 0.
- R6: A reel offset changes only at a clock edge where frame_start is high. A pixel fetched in the same cycle as frame_start still uses the offset from before that edge.
- R7: At a frame_start edge with reel_spin[r] high, reel r's offset advances by STEP_ROWS modulo N_SYMBOLS*64, and reel_done[r] goes to 0.
- R8: At a frame_start edge with reel_spin[r] low and reel_done[r] low, the reel steps unless its offset already equals stop*64. reel_done[r] rises at the same edge where the offset reaches stop*64, or at the next frame_start edge if the offset was already there. Once done, the offset holds until spin rises again.
- R9: After reset every offset is 0, every reel_done bit is 0, and pix_valid and pix_rgb are 0.
- R10: Reel r covers x in [REEL_X0 + r*REEL_PITCH, +128) and y in [REEL_Y0, REEL_Y0+128). The stop symbol of reel r is reel_stop[r*2 +: 2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pix_active | input | 1 | Current pixel is in the visible area |
| pix_x | input | XY_W | Screen column of the current pixel |
| pix_y | input | XY_W | Screen row of the current pixel |
| reel_spin | input | N_REELS | Spin request per reel |
| reel_stop | input | N_REELS*SYM_W | Stop symbol index per reel |
| reel_done | output | N_REELS | Reel has landed on its stop symbol |
| rom_en | output | 1 | A sprite word is being fetched this cycle |
| rom_sym | output | SYM_W | Symbol number of the fetch |
| rom_bank | output | 2 | Bank select within the symbol |
| rom_addr | output | 8 | Word address within the bank |
| rom_data | input | 16 | Registered memory data, two cycles after the address |
| pix_valid | output | 1 | pix_active delayed to line up with rom_data |
| pix_rgb | output | 3 | Pixel colour, one bit each for R, G, B |

## Verification
The frame-boundary offset update and a pixel fetch can fall in the same cycle, because frame_start is an ordinary input and nothing stops a visible pixel from arriving with it. The bench drives a reel-window pixel together with a frame_start pulse on a spinning reel whose offset is at the last row group of the strip. It checks that the address and the colour two cycles later come from the pre-update offset (last symbol). It then checks that the same pixel one cycle later reads symbol 0 after the wrap. The bench also walks back-to-back pixels through the pipeline so that a misaligned nibble select or valid delay shows up as a colour or valid mismatch.

// File: rtl/reel_fetch_pkg.sv
package reel_fetch_pkg;

  localparam int SPR_LOG2     = 6;
  localparam int SPR_DIM      = 1 << SPR_LOG2;
  localparam int WIN_LOG2     = SPR_LOG2 + 1;
  localparam int NIB_W        = 4;
  localparam int WORD_W       = 16;
  localparam int NIB_PER_WORD = WORD_W / NIB_W;
  localparam int NSEL_W       = $clog2(NIB_PER_WORD);
  localparam int WIDX_W       = 2 * SPR_LOG2 - NSEL_W;
  localparam int BANK_AW      = 8;
  localparam int BANK_SEL_W   = WIDX_W - BANK_AW;
  localparam int RGB_W        = 3;

  typedef struct packed {
    logic              act;
    logic              fetch;
    logic [NSEL_W-1:0] nsel;
  } px_meta_t;

  // Word index within one symbol: row selects a run of 16 words, column/4 the word.
  function automatic logic [WIDX_W-1:0] word_index(input logic [SPR_LOG2-1:0] row,
                                                   input logic [SPR_LOG2-1:0] col);
    return {row, col[SPR_LOG2-1:NSEL_W]};
  endfunction

  // Nibble k sits at bits [4k+3:4k]; found by shifting, not dividing.
  function automatic logic [NIB_W-1:0] pick_nibble(input logic [WORD_W-1:0] w,
                                                   input logic [NSEL_W-1:0] sel);
    return w[{sel, 2'b00} +: NIB_W];
  endfunction

  // a + b reduced once by lim; valid while both operands are below lim.
  function automatic logic [15:0] wrap_add(input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] lim);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, lim}) s = s - {1'b0, lim};
    return s[15:0];
  endfunction

endpackage

// File: rtl/reel_scroll.sv
module reel_scroll
  import reel_fetch_pkg::*;
#(
  parameter int N_SYMBOLS = 4,
  parameter int STEP_ROWS = 4,
  parameter int SYM_W     = 2,
  parameter int OFF_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             spin,
  input  logic [SYM_W-1:0] stop_sym,
  output logic [OFF_W-1:0] off,
  output logic             done
);

  localparam int TOTAL = N_SYMBOLS * SPR_DIM;

  logic [OFF_W-1:0] off_q, off_next, target;
  logic             done_q;
  logic             at_target, next_hits;
  logic             step_evt, land_evt;

  assign target    = OFF_W'(stop_sym) << SPR_LOG2;
  assign off_next  = OFF_W'(wrap_add(16'(off_q), 16'(STEP_ROWS), 16'(TOTAL)));
  assign at_target = (off_q == target);
  assign next_hits = (off_next == target);

  // Named events for the checks below.
  assign step_evt = frame_start && (spin || (!done_q && !at_target));
  assign land_evt = frame_start && !spin && !done_q && (at_target || next_hits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q  <= '0;
      done_q <= 1'b0;
    end else if (frame_start) begin
      if (spin) begin
        off_q  <= off_next;
        done_q <= 1'b0;
      end else if (!done_q) begin
        if (at_target) begin
          done_q <= 1'b1;
        end else begin
          off_q  <= off_next;
          done_q <= next_hits;
        end
      end
    end
  end

  assign off  = off_q;
  assign done = done_q;

  p_off_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, off_q} < (OFF_W+1)'(TOTAL)));

  p_off_frame_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(off_q));

  p_spin_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && spin) |=> (off_q != $past(off_q)) && !done_q);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !spin) |=> $stable(off_q) && done_q);

  p_land_on_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> (off_q == $past(target)) && $past(land_evt));

  p_step_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !step_evt) |=> $stable(off_q));

endmodule

// File: rtl/reel_pixel_map.sv
module reel_pixel_map
  import reel_fetch_pkg::*;
#(
  parameter int N_REELS    = 3,
  parameter int N_SYMBOLS  = 4,
  parameter int XY_W       = 10,
  parameter int REEL_X0    = 64,
  parameter int REEL_PITCH = 192,
  parameter int REEL_Y0    = 176,
  parameter int SYM_W      = 2,
  parameter int OFF_W      = 8
) (
  input  logic                     pix_active,
  input  logic [XY_W-1:0]          pix_x,
  input  logic [XY_W-1:0]          pix_y,
  input  logic [N_REELS*OFF_W-1:0] offs,
  output logic                     fetch,
  output logic [SYM_W-1:0]         sym,
  output logic [BANK_SEL_W-1:0]    bank,
  output logic [BANK_AW-1:0]       baddr,
  output logic [NSEL_W-1:0]        nsel
);

  localparam int TOTAL = N_SYMBOLS * SPR_DIM;
  localparam int WIN   = 1 << WIN_LOG2;

  logic                hit_x, hit_y;
  int                  lx_c;
  int                  rsel_c;
  logic [SPR_LOG2-1:0] sx, sy, row_c;
  logic [OFF_W-1:0]    off_sel, srow;
  logic [SYM_W-1:0]    sym_c;
  logic [WIDX_W-1:0]   widx;

  // Horizontal window decode: windows do not overlap, so at most one hits.
  always_comb begin
    hit_x  = 1'b0;
    lx_c   = 0;
    rsel_c = 0;
    for (int r = 0; r < N_REELS; r++) begin
      if (int'(pix_x) >= REEL_X0 + r*REEL_PITCH &&
          int'(pix_x) <  REEL_X0 + r*REEL_PITCH + WIN) begin
        hit_x  = 1'b1;
        lx_c   = int'(pix_x) - REEL_X0 - r*REEL_PITCH;
        rsel_c = r;
      end
    end
  end

  assign hit_y = (int'(pix_y) >= REEL_Y0) && (int'(pix_y) < REEL_Y0 + WIN);

  // Pixel doubling by a right shift of the window-local coordinate.
  assign sx = SPR_LOG2'(lx_c >> 1);
  assign sy = SPR_LOG2'((int'(pix_y) - REEL_Y0) >> 1);

  assign off_sel = offs[rsel_c*OFF_W +: OFF_W];
  assign srow    = OFF_W'(wrap_add(16'(off_sel), 16'(sy), 16'(TOTAL)));
  assign sym_c   = SYM_W'(srow >> SPR_LOG2);
  assign row_c   = srow[SPR_LOG2-1:0];
  assign widx    = word_index(row_c, sx);

  assign fetch = pix_active && hit_x && hit_y;
  assign sym   = fetch ? sym_c : '0;
  assign bank  = fetch ? widx[WIDX_W-1:BANK_AW] : '0;
  assign baddr = fetch ? widx[BANK_AW-1:0] : '0;
  assign nsel  = fetch ? sx[NSEL_W-1:0] : '0;

endmodule

// File: rtl/reel_pixel_pipe.sv
module reel_pixel_pipe
  import reel_fetch_pkg::*;
#(
  parameter int ROM_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              fetch,
  input  logic [NSEL_W-1:0] nsel,
  input  logic [WORD_W-1:0] rom_data,
  output logic              pix_valid,
  output logic [RGB_W-1:0]  pix_rgb
);

  px_meta_t         meta_q [ROM_LAT];
  logic [NIB_W-1:0] nib;
  logic             started;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ROM_LAT; k++) meta_q[k] <= '0;
      started <= 1'b0;
    end else begin
      meta_q[0] <= px_meta_t'({act, fetch, nsel});
      for (int k = 1; k < ROM_LAT; k++) meta_q[k] <= meta_q[k-1];
      started <= 1'b1;
    end
  end

  assign nib       = pick_nibble(rom_data, meta_q[ROM_LAT-1].nsel);
  assign pix_valid = meta_q[ROM_LAT-1].act;
  assign pix_rgb   = meta_q[ROM_LAT-1].fetch ? nib[RGB_W-1:0] : '0;

  p_meta_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (meta_q[0] == $past(px_meta_t'({act, fetch, nsel}))));

  for (genvar k = 1; k < ROM_LAT; k++) begin : g_lag
    p_meta_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (meta_q[k] == $past(meta_q[k-1])));
  end

  p_black_when_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> (pix_rgb == '0));

endmodule

// File: rtl/reel_sprite_fetch.sv
module reel_sprite_fetch
  import reel_fetch_pkg::*;
#(
  parameter int N_REELS    = 3,
  parameter int N_SYMBOLS  = 4,
  parameter int STEP_ROWS  = 4,
  parameter int ROM_LAT    = 2,
  parameter int XY_W       = 10,
  parameter int REEL_X0    = 64,
  parameter int REEL_PITCH = 192,
  parameter int REEL_Y0    = 176,
  localparam int SYM_W     = (N_SYMBOLS > 1) ? $clog2(N_SYMBOLS) : 1,
  localparam int OFF_W     = $clog2(N_SYMBOLS * SPR_DIM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     pix_active,
  input  logic [XY_W-1:0]          pix_x,
  input  logic [XY_W-1:0]          pix_y,
  input  logic [N_REELS-1:0]       reel_spin,
  input  logic [N_REELS*SYM_W-1:0] reel_stop,
  output logic [N_REELS-1:0]       reel_done,
  output logic                     rom_en,
  output logic [SYM_W-1:0]         rom_sym,
  output logic [BANK_SEL_W-1:0]    rom_bank,
  output logic [BANK_AW-1:0]       rom_addr,
  input  logic [WORD_W-1:0]        rom_data,
  output logic                     pix_valid,
  output logic [RGB_W-1:0]         pix_rgb
);

  logic [N_REELS*OFF_W-1:0] offs;
  logic [NSEL_W-1:0]        nsel;

  for (genvar r = 0; r < N_REELS; r++) begin : g_reel
    reel_scroll #(
      .N_SYMBOLS (N_SYMBOLS),
      .STEP_ROWS (STEP_ROWS),
      .SYM_W     (SYM_W),
      .OFF_W     (OFF_W)
    ) u_scroll (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .spin        (reel_spin[r]),
      .stop_sym    (reel_stop[r*SYM_W +: SYM_W]),
      .off         (offs[r*OFF_W +: OFF_W]),
      .done        (reel_done[r])
    );
  end

  reel_pixel_map #(
    .N_REELS    (N_REELS),
    .N_SYMBOLS  (N_SYMBOLS),
    .XY_W       (XY_W),
    .REEL_X0    (REEL_X0),
    .REEL_PITCH (REEL_PITCH),
    .REEL_Y0    (REEL_Y0),
    .SYM_W      (SYM_W),
    .OFF_W      (OFF_W)
  ) u_map (
    .pix_active (pix_active),
    .pix_x      (pix_x),
    .pix_y      (pix_y),
    .offs       (offs),
    .fetch      (rom_en),
    .sym        (rom_sym),
    .bank       (rom_bank),
    .baddr      (rom_addr),
    .nsel       (nsel)
  );

  reel_pixel_pipe #(
    .ROM_LAT (ROM_LAT)
  ) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (pix_active),
    .fetch     (rom_en),
    .nsel      (nsel),
    .rom_data  (rom_data),
    .pix_valid (pix_valid),
    .pix_rgb   (pix_rgb)
  );

  p_fetch_in_rows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (pix_active && (int'(pix_y) >= REEL_Y0) &&
                (int'(pix_y) < REEL_Y0 + (1 << WIN_LOG2))));

  p_sym_in_strip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rom_en |-> (int'(rom_sym) < N_SYMBOLS));

endmodule

// File: tb/reel_sprite_fetch_tb.sv
module reel_sprite_fetch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSYM  = 4;
  localparam int STEP  = 4;
  localparam int TOTAL = NSYM * 64;
  localparam int NV    = 13;

  // {active, x, y}
  localparam logic [20:0] TBL [NV] = '{
    {1'b1, 10'd64,  10'd176},   // reel0 top-left
    {1'b1, 10'd65,  10'd176},   // R1 doubled column
    {1'b1, 10'd64,  10'd177},   // R1 doubled row
    {1'b1, 10'd71,  10'd177},   // nibble 3
    {1'b1, 10'd69,  10'd180},   // nibble 2
    {1'b1, 10'd191, 10'd303},   // last word, bank 3
    {1'b1, 10'd256, 10'd176},   // reel1 last symbol
    {1'b1, 10'd300, 10'd184},   // reel1 wraps to symbol 0
    {1'b1, 10'd448, 10'd200},   // reel2
    {1'b1, 10'd575, 10'd303},   // reel2 bottom-right
    {1'b1, 10'd10,  10'd176},   // left of reel0
    {1'b1, 10'd200, 10'd200},   // gap between reels
    {1'b0, 10'd64,  10'd176}    // blanking
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       pix_active = 1'b0;
  logic [9:0] pix_x = '0, pix_y = '0;
  logic [2:0] reel_spin = '0;
  logic [5:0] reel_stop = '0;
  logic [2:0] reel_done;
  logic       rom_en;
  logic [1:0] rom_sym, rom_bank;
  logic [7:0] rom_addr;
  logic [15:0] rom_data;
  logic       pix_valid;
  logic [2:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  int m_off  [3];
  bit m_done [3];
  int m_stop [3];

  logic [15:0] rom_mem [NSYM*1024];
  logic [15:0] rd1, rd2;

  always #(CLK_PERIOD/2) clk = ~clk;

  reel_sprite_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_active(pix_active),
    .pix_x(pix_x), .pix_y(pix_y), .reel_spin(reel_spin), .reel_stop(reel_stop),
    .reel_done(reel_done), .rom_en(rom_en), .rom_sym(rom_sym), .rom_bank(rom_bank),
    .rom_addr(rom_addr), .rom_data(rom_data), .pix_valid(pix_valid), .pix_rgb(pix_rgb)
  );

  // Registered-output memory: two cycles from address to data.
  always_ff @(posedge clk) begin
    rd1 <= rom_mem[{rom_sym, rom_bank, rom_addr}];
    rd2 <= rd1;
  end
  assign rom_data = rd2;

  function automatic int pix_fn(int s, int row, int col);
    return (s*5 + row*3 + col) % 16;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic calc(input bit act, input int x, input int y, output bit f,
                      output int s, output int bank, output int addr, output int rgb);
    int r, srow, row, col, widx;
    r = -1;
    for (int k = 0; k < 3; k++)
      if (x >= 64 + 192*k && x < 64 + 192*k + 128) r = k;
    f = act && (r >= 0) && (y >= 176) && (y < 304);
    s = 0; bank = 0; addr = 0; rgb = 0;
    if (f) begin
      srow = (m_off[r] + (y - 176)/2) % TOTAL;
      s    = srow / 64;
      row  = srow % 64;
      col  = (x - 64 - 192*r) / 2;
      widx = row*16 + col/4;
      bank = widx / 256;
      addr = widx % 256;
      rgb  = pix_fn(s, row, col) % 8;
    end
  endtask

  task automatic model_frame();
    for (int r = 0; r < 3; r++) begin
      if (reel_spin[r]) begin
        m_off[r] = (m_off[r] + STEP) % TOTAL; m_done[r] = 0;
      end else if (!m_done[r]) begin
        if (m_off[r] == m_stop[r]*64) m_done[r] = 1;
        else begin
          m_off[r] = (m_off[r] + STEP) % TOTAL;
          m_done[r] = (m_off[r] == m_stop[r]*64);
        end
      end
    end
  endtask

  task automatic set_stops();
    reel_stop = {2'(m_stop[2]), 2'(m_stop[1]), 2'(m_stop[0])};
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    model_frame();
  endtask

  task automatic check_done(input string tag);
    chk(tag, int'(reel_done), {29'd0, m_done[2], m_done[1], m_done[0]});
  endtask

  // Drive one pixel, check the fetch address in the same cycle.
  task automatic probe(input string tag, input int x, input int y);
    bit f; int s, b, a, c;
    pix_active = 1'b1; pix_x = 10'(x); pix_y = 10'(y);
    #1;
    calc(1'b1, x, y, f, s, b, a, c);
    chk({tag, " rom_en"}, int'(rom_en), int'(f));
    chk({tag, " rom_sym"}, int'(rom_sym), s);
    chk({tag, " rom_addr"}, int'(rom_bank)*256 + int'(rom_addr), b*256 + a);
    @(negedge clk);
    pix_active = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit   ef [NV];
    int   ergb [NV];
    bit   eact [NV];
    for (int s = 0; s < NSYM; s++)
      for (int row = 0; row < 64; row++)
        for (int w = 0; w < 16; w++) begin
          logic [15:0] word;
          for (int k = 0; k < 4; k++) word[k*4 +: 4] = 4'(pix_fn(s, row, w*4 + k));
          rom_mem[s*1024 + row*16 + w] = word;
        end
    for (int r = 0; r < 3; r++) begin m_off[r] = 0; m_done[r] = 0; m_stop[r] = 0; end
    set_stops();

    repeat (3) @(negedge clk);
    // R9: reset state
    check_done("R9 reset done");
    chk("R9 reset valid", int'(pix_valid), 0);
    chk("R9 reset rgb", int'(pix_rgb), 0);
    rst_n = 1'b1;
    @(negedge clk);
    probe("R9 reset offset", 64, 176);

    // R7: reels 0 and 1 spin; R8: reel2 idle at its target
    reel_spin = 3'b011;
    frame();
    check_done("R8 already at target");
    for (int i = 1; i < 15; i++) frame();
    chk("R7 no done while spinning", int'(reel_done[1:0]), 0);
    probe("R7 reel0 stepped", 64, 176);
    // R6: no frame_start, offsets stay
    repeat (5) @(negedge clk);
    probe("R6 held without frame", 64, 176);

    // R8: reel0 lands on symbol 1 in the same frame it reaches it
    reel_spin = 3'b010; m_stop[0] = 1; set_stops();
    frame();
    check_done("R8 land same frame");
    for (int i = 16; i < 63; i++) frame();
    check_done("R8 done holds");
    probe("R8 reel0 offset held", 64, 176);
    probe("R7 reel1 offset", 256, 176);

    // R1 R2 R3 R4 R5 R10: back-to-back table walk
    for (int i = 0; i < NV + 2; i++) begin
      if (i >= 2) begin
        chk($sformatf("R3 R4 valid vec %0d", i-2), int'(pix_valid), int'(eact[i-2]));
        chk($sformatf("R1 R2 R5 rgb vec %0d", i-2), int'(pix_rgb), ergb[i-2]);
      end
      if (i < NV) begin
        int s, b, a;
        pix_active = TBL[i][20]; pix_x = TBL[i][19:10]; pix_y = TBL[i][9:0];
        #1;
        calc(TBL[i][20], int'(TBL[i][19:10]), int'(TBL[i][9:0]), ef[i], s, b, a, ergb[i]);
        eact[i] = TBL[i][20];
        chk($sformatf("R4 R10 rom_en vec %0d", i), int'(rom_en), int'(ef[i]));
        if (ef[i]) begin
          chk($sformatf("R2 R5 sym vec %0d", i), int'(rom_sym), s);
          chk($sformatf("R2 bank vec %0d", i), int'(rom_bank), b);
          chk($sformatf("R2 addr vec %0d", i), int'(rom_addr), a);
        end
      end else begin
        pix_active = 1'b0;
      end
      @(negedge clk);
    end

    // R6 R5 R7: pixel in the same cycle as frame_start uses the old offset
    begin
      bit f; int s, b, a, c0, c1;
      reel_spin = 3'b011;
      pix_active = 1'b1; pix_x = 10'd256; pix_y = 10'd176; frame_start = 1'b1;
      #1;
      calc(1'b1, 256, 176, f, s, b, a, c0);
      chk("R6 same-cycle sym", int'(rom_sym), s);
      chk("R6 same-cycle addr", int'(rom_bank)*256 + int'(rom_addr), b*256 + a);
      @(negedge clk);
      frame_start = 1'b0;
      model_frame();
      #1;
      calc(1'b1, 256, 176, f, s, b, a, c1);
      chk("R5 wrap to symbol 0", int'(rom_sym), s);
      chk("R5 wrap addr", int'(rom_bank)*256 + int'(rom_addr), b*256 + a);
      @(negedge clk);
      pix_active = 1'b0;
      chk("R6 same-cycle rgb old offset", int'(pix_rgb), c0);
      @(negedge clk);
      chk("R5 rgb after wrap", int'(pix_rgb), c1);
      check_done("R7 spin clears done");
    end

    // R8: reel0 steps all the way round back to symbol 1
    reel_spin = 3'b010;
    for (int i = 0; i < 62; i++) frame();
    chk("R8 not landed early", int'(reel_done[0]), 0);
    frame();
    chk("R8 landed after full lap", int'(reel_done[0]), 1);
    probe("R8 lap offset", 64, 176);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule